// File: doc/BRIEF.md
# Glitch-free clock source selector

This block drives the clock of one clock domain from one of five free-running source clocks. Software chooses the source through a 3-bit field of a configuration register, reached by a simple masked write port and a combinational read port, both clocked by the register clock. The block accepts a new choice only if it is a legal source, it differs from the current one, and no earlier change is still pending. It then moves the output clock across without a shortened pulse and reports the hand-over in a busy bit.

The hand-over works in three steps. The old source is turned off on its own falling edge. The new source waits two of its own rising edges after it sees every other source off. It then turns on at its own falling edge. The enable of each source is synchronised back into the register clock, and busy clears once exactly the requested source is seen on. Software polls busy before it writes the select field again. The bits of the register above the status bit are plain storage for the stage that follows, and this block does not interpret them.

Top module: `clk_src_sel`

## Requirements
- R1: After reset the select field reads 0, busy (bit 3) reads 0, the upper bits read 0, and `clk_o` follows source 0.
- R2: The select field is bits [2:0]. Value n (0 main oscillator, 1 real-time oscillator, 2/3/4 first/second/third PLL) makes `clk_o` follow `src_clk_i[n]` once the switch completes.
- R3: An accepted select write makes bit 3 read 1 in the register-clock cycle after the write edge. The select field reads the new value in that same cycle.
- R4: Busy returns to 0 on its own once only the new source is enabled. It is guaranteed to be 0 within 2000 register-clock cycles for the default source frequencies.
- R5: A select value of 5, 6 or 7 is ignored. The select field keeps its value and busy stays 0.
- R6: A select write made while busy reads 1 is ignored. The pending switch completes to the earlier value.
- R7: A write changes only the bits whose `wr_mask_i` bit is 1. Bit 3 is read-only and cannot be written. Upper bits [31:4] store written data even when the select part of the same write is ignored.
- R8: At no time is more than one source enabled. No high or low phase of `clk_o` is shorter than the shortest half period among the source clocks.
- R9: Writing the value the select field already holds does not set busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_clk_i | input | 5 | Source clocks, index = select code |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data |
| wr_mask_i | input | 32 | Per-bit write enable |
| rd_data_o | output | 32 | Register read value: upper, busy, select |
| clk_o | output | 1 | Selected domain clock |

## Verification
A write is driven on a falling edge of the register clock and captured at the next rising edge. The select field, busy bit and upper bits are therefore compared at the following falling edge, exactly one cycle after the stimulus. Busy clears only after a number of source-clock edges plus two register-clock synchronising stages, so no fixed cycle count can be given for it. The bench polls bit 3 on every falling edge up to a 2000-cycle bound. Only after busy clears does it time two consecutive rising edges of `clk_o` against the expected source period. A pulse-width monitor runs for the whole test to catch any shortened phase.

// File: rtl/clk_sel_pkg.sv
package clk_sel_pkg;
  parameter int unsigned NUM_SRC  = 5;
  parameter int unsigned SEL_W    = 3;
  parameter int unsigned DATA_W   = 32;
  parameter int unsigned BUSY_BIT = SEL_W;

  typedef enum logic [SEL_W-1:0] {
    SRC_OSC  = 3'd0,
    SRC_RTC  = 3'd1,
    SRC_PLL1 = 3'd2,
    SRC_PLL2 = 3'd3,
    SRC_PLL3 = 3'd4
  } src_e;
endpackage

// File: rtl/csel_sync2.sv
module csel_sync2 #(
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/csel_gate.sv
// Per-source enable cell: two rising-edge sync stages, then a falling-edge enable flop.
module csel_gate #(
  parameter logic RST_ON = 1'b0
) (
  input  logic src_clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic others_on_i,
  output logic en_o
);
  logic arm;
  logic en_q;

  csel_sync2 #(.W(1), .RST_VAL(RST_ON)) u_sync (
    .clk_i  (src_clk_i),
    .rst_ni (rst_ni),
    .d_i    (req_i & ~others_on_i),
    .q_o    (arm)
  );

  // changes only while src_clk_i is low
  always_ff @(negedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= RST_ON;
    else         en_q <= arm;
  end

  assign en_o = en_q;
endmodule

// File: rtl/csel_ctrl.sv
module csel_ctrl #(
  parameter int unsigned NUM_SRC = 5,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [DATA_W-1:0]  wr_mask_i,
  input  logic [NUM_SRC-1:0] en_sync_i,
  output logic [SEL_W-1:0]   sel_o,
  output logic               busy_o,
  output logic [DATA_W-1:0]  rd_data_o
);
  localparam int unsigned UP_LSB = SEL_W + 1;
  localparam int unsigned UP_W   = DATA_W - UP_LSB;

  logic [SEL_W-1:0]   sel_q, sel_new;
  logic               busy_q, take, done;
  logic [UP_W-1:0]    up_q;
  logic [NUM_SRC-1:0] tgt;

  always_comb begin
    sel_new = (sel_q & ~wr_mask_i[SEL_W-1:0]) | (wr_data_i[SEL_W-1:0] & wr_mask_i[SEL_W-1:0]);
    take    = wr_en_i && (|wr_mask_i[SEL_W-1:0]) && !busy_q &&
              (32'(sel_new) < NUM_SRC) && (sel_new != sel_q);
    for (int i = 0; i < NUM_SRC; i++) tgt[i] = (sel_q == SEL_W'(i));
    done = (en_sync_i == tgt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      busy_q <= 1'b0;
      up_q   <= '0;
    end else begin
      if (take) begin
        sel_q  <= sel_new;
        busy_q <= 1'b1;
      end else if (busy_q && done) begin
        busy_q <= 1'b0;
      end
      if (wr_en_i)
        up_q <= (up_q & ~wr_mask_i[DATA_W-1:UP_LSB]) | (wr_data_i[DATA_W-1:UP_LSB] & wr_mask_i[DATA_W-1:UP_LSB]);
    end
  end

  assign sel_o     = sel_q;
  assign busy_o    = busy_q;
  assign rd_data_o = {up_q, busy_q, sel_q};
endmodule

// File: rtl/clk_src_sel.sv
module clk_src_sel #(
  parameter int unsigned NUM_SRC = clk_sel_pkg::NUM_SRC,
  parameter int unsigned SEL_W   = clk_sel_pkg::SEL_W,
  parameter int unsigned DATA_W  = clk_sel_pkg::DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_clk_i,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [DATA_W-1:0]  wr_mask_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               clk_o
);
  localparam logic [NUM_SRC-1:0] EN_RST = NUM_SRC'(1);

  logic [SEL_W-1:0]   sel_q;
  logic               busy_q;
  logic [NUM_SRC-1:0] en, en_sync, req, others_on;

  csel_ctrl #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .wr_mask_i (wr_mask_i),
    .en_sync_i (en_sync),
    .sel_o     (sel_q),
    .busy_o    (busy_q),
    .rd_data_o (rd_data_o)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign req[g]       = (sel_q == SEL_W'(g));
    assign others_on[g] = |(en & ~(NUM_SRC'(1) << g));
    csel_gate #(.RST_ON(g == 0)) u_gate (
      .src_clk_i   (src_clk_i[g]),
      .rst_ni      (rst_ni),
      .req_i       (req[g]),
      .others_on_i (others_on[g]),
      .en_o        (en[g])
    );
  end

  csel_sync2 #(.W(NUM_SRC), .RST_VAL(EN_RST)) u_en_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (en),
    .q_o    (en_sync)
  );

  assign clk_o = |(src_clk_i & en);
endmodule

// File: rtl/clk_src_sel_chk.sv
module clk_src_sel_chk #(
  parameter int unsigned NUM_SRC = 5,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned DATA_W  = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [DATA_W-1:0]  wr_data_i,
  input logic [DATA_W-1:0]  wr_mask_i,
  input logic [DATA_W-1:0]  rd_data_o,
  input logic [NUM_SRC-1:0] en
);
  localparam int unsigned UP_LSB = SEL_W + 1;
  logic [SEL_W-1:0] sel;
  logic             busy;
  assign sel  = rd_data_o[SEL_W-1:0];
  assign busy = rd_data_o[SEL_W];

  p_sel_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(sel) < NUM_SRC);

  p_busy_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_mask_i[SEL_W-1:0] == '1 && !busy &&
     32'(wr_data_i[SEL_W-1:0]) < NUM_SRC && wr_data_i[SEL_W-1:0] != sel) |=> busy);

  p_invalid_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_mask_i[SEL_W-1:0] == '1 && 32'(wr_data_i[SEL_W-1:0]) >= NUM_SRC)
    |=> $stable(sel));

  p_hold_while_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(sel));

  p_masked_upper_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i || wr_mask_i[DATA_W-1:UP_LSB] == '0) |=> $stable(rd_data_o[DATA_W-1:UP_LSB]));

  p_single_source_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(en));

  p_same_value_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && wr_en_i && wr_mask_i[SEL_W-1:0] == '1 && wr_data_i[SEL_W-1:0] == sel) |=> !busy);
endmodule

bind clk_src_sel clk_src_sel_chk #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .wr_mask_i (wr_mask_i),
  .rd_data_o (rd_data_o),
  .en        (en)
);

// File: tb/clk_src_sel_bench.sv
`timescale 1ns/1ps
module clk_src_sel_bench;
  localparam int NS = 5;
  localparam real HP [NS] = '{19.0, 100.0, 3.0, 4.0, 5.0};  // half periods, ns

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b1;
  logic [NS-1:0] src_clk = '0;
  logic          wr_en_i = 1'b0;
  logic [31:0]   wr_data_i = '0;
  logic [31:0]   wr_mask_i = '0;
  logic [31:0]   rd_data_o;
  logic          clk_o;

  int  checks = 0;
  int  errors = 0;
  bit  mon_on = 0;
  bit  mon_armed = 0;
  real last_edge = 0.0;
  real min_pulse = 1.0e9;

  clk_src_sel u_clk_src_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_clk_i (src_clk),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .wr_mask_i (wr_mask_i),
    .rd_data_o (rd_data_o),
    .clk_o     (clk_o)
  );

  always #2 clk_i = ~clk_i;
  for (genvar g = 0; g < NS; g++) begin : g_clk
    initial forever #(HP[g]) src_clk[g] = ~src_clk[g];
  end

  always @(clk_o) begin
    if (mon_on) begin
      if (mon_armed && ($realtime - last_edge) < min_pulse) min_pulse = $realtime - last_edge;
      last_edge = $realtime;
      mon_armed = 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d, input logic [31:0] m);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = d; wr_mask_i = m;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = '0; wr_mask_i = '0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (rd_data_o[3] && n < 2000) begin
      @(negedge clk_i);
      n++;
    end
    chk(req, {31'd0, rd_data_o[3]}, 32'd0);
  endtask

  task automatic chk_period(input string req, input int src);
    real t0, t1;
    int  p_act, p_exp;
    @(posedge clk_o); t0 = $realtime;
    @(posedge clk_o); t1 = $realtime;
    p_act = int'((t1 - t0) * 10.0);
    p_exp = int'(HP[src] * 20.0);
    chk(req, 32'(p_act), 32'(p_exp));
  endtask

  task automatic t_reset();
    chk("R1", rd_data_o, 32'h0);
    chk_period("R1", 0);
  endtask

  task automatic t_switch(input int src);
    wr(32'(src), 32'h7);
    chk("R3", rd_data_o[3:0], {1'b1, 3'(src)});
    wait_idle("R4");
    chk("R2", {29'd0, rd_data_o[2:0]}, 32'(src));
    chk_period("R2", src);
  endtask

  task automatic t_invalid();
    for (int v = 5; v < 8; v++) begin
      wr(32'(v), 32'h7);
      chk("R5", {28'd0, rd_data_o[3:0]}, 32'h4);
    end
    chk_period("R5", 4);
  endtask

  task automatic t_busy_ignore();
    wr(32'h2, 32'h7);
    wr(32'h3, 32'h7);
    chk("R6", {29'd0, rd_data_o[2:0]}, 32'h2);
    wait_idle("R6");
    chk("R6", {29'd0, rd_data_o[2:0]}, 32'h2);
    chk_period("R6", 2);
  endtask

  task automatic t_mask();
    wr(32'hABCD_EF03, 32'hFFFF_FFF0);
    chk("R7", rd_data_o, 32'hABCD_EF02);
    wr(32'h0000_0003, 32'h0000_0007);
    chk("R7", rd_data_o[31:4], 28'hABCD_EF0);
    wait_idle("R7");
    wr(32'h0000_0008, 32'h0000_0008);
    chk("R7", rd_data_o, 32'hABCD_EF03);
    wr(32'h1234_5677, 32'hFFFF_FFFF);
    chk("R7", rd_data_o, 32'h1234_5673);
    wr(32'h0, 32'hFFFF_FFF0);
  endtask

  task automatic t_same();
    wr(32'h3, 32'h7);
    chk("R9", {28'd0, rd_data_o[3:0]}, 32'h3);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    #40 rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    t_reset();
    mon_on = 1;
    t_switch(1);
    t_switch(2);
    t_switch(3);
    t_switch(4);
    t_invalid();
    t_switch(0);
    t_busy_ignore();
    t_mask();
    t_same();
    t_switch(1);
    t_switch(0);
    checks++;
    if (min_pulse < 2.99) begin
      errors++;
      $display("FAIL R8 actual=%0.3f expected>=3.000", min_pulse);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule